// File: doc/BRIEF.md
# Pulse-Pause Frame Encoder

This block sends one reader-to-card frame on a single carrier-enable line. It uses pulse-pause encoding. Every bit opens with a short, fixed interval in which the carrier is off. The carrier is then switched back on for the rest of the bit period, and the total length of that period gives the bit's value. A long period means 1 and a short period means 0. Bits leave least significant first.

Before a bit's duration is chosen, the data bit is XORed with a keystream bit that an external generator supplies. The block asks that generator for the next keystream bit through a one-cycle advance strobe, once per transmitted bit. After the last bit, one more carrier-off interval marks the end of the frame. The carrier is then restored and a done pulse is issued.

All intervals are counted in ticks. A tick is a clock cycle in which `tick_en` is high. At frame end a free-running response-window counter restarts, so the card's answer can be timed from that point.

Top module: `pulse_pause_tx`

## Requirements
- R1: After reset the carrier is high, `busy`, `done` and `ks_adv` are low, and `resp_ticks` is 0.
- R2: Every transmitted bit begins with the carrier low for exactly `PAUSE_TICKS` ticks.
- R3: The encoded value of a bit is the data bit XOR the keystream bit. An encoded 1 lasts `ONE_TICKS` ticks in total and an encoded 0 lasts `ZERO_TICKS` ticks in total, the opening pause included.
- R4: Data bits are sent in order from bit 0 (least significant) upwards.
- R5: `ks_adv` pulses for one cycle per transmitted bit, in the cycle where that bit's `ks_bit` is taken. For bit 0 this is the cycle in which the start is accepted. For each later bit it is the tick that ends the previous bit. The carrier is low in the following cycle.
- R6: After the last bit the carrier is low for a further `PAUSE_TICKS` ticks and then returns high. A bit count of 0 produces only this closing pause.
- R7: A start is accepted only while idle. `busy` rises in the cycle after an accepted start and stays high until the carrier returns high after the closing pause. A start while busy changes nothing.
- R8: `done` is high for exactly one cycle, the first cycle in which the carrier is high again after the closing pause.
- R9: `resp_ticks` is 0 in the `done` cycle. It then counts ticks, saturating at its all-ones value.
- R10: A bit count larger than `DATA_W` is treated as `DATA_W`.
- R11: In a cycle without a tick, a busy frame does not advance. The carrier and `busy` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timing base: one tick per high cycle |
| start | input | 1 | Request to send a frame (taken when idle) |
| data_in | input | DATA_W | Frame payload, bit 0 sent first |
| nbits_in | input | $clog2(DATA_W+1) | Number of bits to send |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | Keystream advance strobe |
| carrier | output | 1 | Carrier enable (high = on) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| resp_ticks | output | RESP_W | Ticks since the last frame end, saturating |

## Verification
The bench builds the block with `DATA_W` = 16, a 3-tick pause, 7 ticks for a 0 and 11 ticks for a 1, and a 5-bit response counter. With these values a full 16-bit frame takes only a few hundred cycles. Bit-count clamping is reachable with a count of 20. The response counter saturates within 40 cycles.

Ticks are applied every cycle for exact run-length checks, and every third cycle or held off entirely to exercise stalls. The keystream comes either from a small LFSR stepped on `ks_adv` or is tied to 0.

// File: rtl/pptx_pkg.sv
// Shared types for the pulse-pause frame encoder.
package pptx_pkg;

    // Frame phases: idle (carrier on), opening pause, carrier-on mark, closing pause.
    typedef enum logic [1:0] {
        PP_IDLE  = 2'd0,
        PP_PAUSE = 2'd1,
        PP_MARK  = 2'd2,
        PP_CLOSE = 2'd3
    } pp_state_e;

endpackage

// File: rtl/pptx_tick_counter.sv
// Tick counter for the current bit or closing pause.
// Counts qualified ticks and is cleared when a new segment starts.
// Assumes the caller clears it before the count can exceed its width.
module pptx_tick_counter #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    output logic [TW-1:0] count
);

    // Count ticks; a clear wins over a simultaneous tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (tick) begin
            count <= count + TW'(1);
        end
    end

endmodule

// File: rtl/pptx_shifter.sv
// Payload store for the frame being sent.
// Holds the bits still to be sent after the current one and how many bits
// remain, the current one included. Bit 0 of the payload is taken directly
// by the controller at load time. Assumes DATA_W >= 2.
module pptx_shifter #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CNT_W-1:0]  nbits_in,
    input  logic              advance,
    output logic              next_bit,
    output logic              last_bit
);

    localparam logic [CNT_W-1:0] MAX_BITS = CNT_W'(DATA_W);

    logic [DATA_W-2:0] rest_q;
    logic [CNT_W-1:0]  remain_q;
    logic [CNT_W-1:0]  clamped;

    // Limit the requested count to the payload width.
    always_comb begin
        clamped = (nbits_in > MAX_BITS) ? MAX_BITS : nbits_in;
    end

    // Load the payload on a start, drop one bit at the end of every bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rest_q   <= '0;
            remain_q <= '0;
        end else if (load) begin
            rest_q   <= data_in[DATA_W-1:1];
            remain_q <= clamped;
        end else if (advance) begin
            rest_q   <= rest_q >> 1;
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    assign next_bit = rest_q[0];
    assign last_bit = (remain_q == CNT_W'(1));

endmodule

// File: rtl/pptx_resp_timer.sv
// Response-window timer.
// Restarts at frame end and counts ticks, holding at its maximum.
// Free-running otherwise, including during a frame.
module pptx_resp_timer #(
    parameter int RESP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    output logic [RESP_W-1:0] ticks
);

    localparam logic [RESP_W-1:0] TOP = '1;

    // Saturating count of ticks since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks <= '0;
        end else if (restart) begin
            ticks <= '0;
        end else if (tick && (ticks != TOP)) begin
            ticks <= ticks + RESP_W'(1);
        end
    end

endmodule

// File: rtl/pptx_fsm.sv
// Frame controller for the pulse-pause encoder.
// Sequences pause/mark per bit and the closing pause, chooses each bit's
// length from data XOR keystream, and strobes the keystream advance.
// Assumes PAUSE_TICKS >= 1 and ZERO_TICKS, ONE_TICKS > PAUSE_TICKS.
module pptx_fsm
    import pptx_pkg::*;
#(
    parameter int TW          = 8,
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS   = 150,
    parameter int ZERO_TICKS  = 90
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          nb_zero,
    input  logic          tick_en,
    input  logic [TW-1:0] cnt,
    input  logic          first_bit,
    input  logic          next_bit,
    input  logic          last_bit,
    input  logic          ks_bit,
    output pp_state_e     state,
    output logic          load,
    output logic          advance,
    output logic          cnt_clear,
    output logic          ks_adv,
    output logic          frame_end,
    output logic          done
);

    localparam logic [TW-1:0] PAUSE_LAST = TW'(PAUSE_TICKS - 1);
    localparam logic [TW-1:0] ONE_LAST   = TW'(ONE_TICKS - 1);
    localparam logic [TW-1:0] ZERO_LAST  = TW'(ZERO_TICKS - 1);

    logic          enc_q;
    logic          accept;
    logic          pause_end;
    logic          bit_end;
    logic [TW-1:0] len_last;

    // Decode the events that end a segment in the current cycle.
    always_comb begin
        len_last  = enc_q ? ONE_LAST : ZERO_LAST;
        accept    = (state == PP_IDLE) && start;
        pause_end = (state == PP_PAUSE) && tick_en && (cnt == PAUSE_LAST);
        bit_end   = (state == PP_MARK) && tick_en && (cnt == len_last);
        frame_end = (state == PP_CLOSE) && tick_en && (cnt == PAUSE_LAST);
        load      = accept;
        advance   = bit_end;
        cnt_clear = accept || bit_end || frame_end;
        ks_adv    = (accept && !nb_zero) || (bit_end && !last_bit);
    end

    // Phase register, encoded value of the current bit, and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PP_IDLE;
            enc_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= frame_end;
            unique case (state)
                PP_IDLE: begin
                    if (accept) begin
                        state <= nb_zero ? PP_CLOSE : PP_PAUSE;
                        enc_q <= first_bit ^ ks_bit;
                    end
                end
                PP_PAUSE: begin
                    if (pause_end) begin
                        state <= PP_MARK;
                    end
                end
                PP_MARK: begin
                    if (bit_end) begin
                        state <= last_bit ? PP_CLOSE : PP_PAUSE;
                        enc_q <= next_bit ^ ks_bit;
                    end
                end
                PP_CLOSE: begin
                    if (frame_end) begin
                        state <= PP_IDLE;
                    end
                end
                default: state <= PP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pulse_pause_tx.sv
// Pulse-pause frame encoder, top level.
// Sends nbits_in bits of data_in, LSB first, each whitened by ks_bit, as
// carrier-off pauses followed by carrier-on marks whose total length gives
// the bit value; ends with a closing pause and a done pulse.
// Assumes tick_en is a single-cycle-per-tick enable and DATA_W >= 2.
module pulse_pause_tx
    import pptx_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS   = 150,
    parameter int ZERO_TICKS  = 90,
    parameter int RESP_W      = 16,
    localparam int CNT_W      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              start,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CNT_W-1:0]  nbits_in,
    input  logic              ks_bit,
    output logic              ks_adv,
    output logic              carrier,
    output logic              busy,
    output logic              done,
    output logic [RESP_W-1:0] resp_ticks
);

    localparam int TW = $clog2(ONE_TICKS + 1);

    pp_state_e     state;
    logic [TW-1:0] cnt;
    logic          load;
    logic          advance;
    logic          cnt_clear;
    logic          frame_end;
    logic          next_bit;
    logic          last_bit;
    logic          nb_zero;

    // Carrier is off only during pauses; busy outside idle.
    always_comb begin
        nb_zero = (nbits_in == '0);
        carrier = !((state == PP_PAUSE) || (state == PP_CLOSE));
        busy    = (state != PP_IDLE);
    end

    pptx_fsm #(
        .TW          (TW),
        .PAUSE_TICKS (PAUSE_TICKS),
        .ONE_TICKS   (ONE_TICKS),
        .ZERO_TICKS  (ZERO_TICKS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .nb_zero   (nb_zero),
        .tick_en   (tick_en),
        .cnt       (cnt),
        .first_bit (data_in[0]),
        .next_bit  (next_bit),
        .last_bit  (last_bit),
        .ks_bit    (ks_bit),
        .state     (state),
        .load      (load),
        .advance   (advance),
        .cnt_clear (cnt_clear),
        .ks_adv    (ks_adv),
        .frame_end (frame_end),
        .done      (done)
    );

    pptx_tick_counter #(
        .TW (TW)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .tick  (tick_en && busy),
        .count (cnt)
    );

    pptx_shifter #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .data_in  (data_in),
        .nbits_in (nbits_in),
        .advance  (advance),
        .next_bit (next_bit),
        .last_bit (last_bit)
    );

    pptx_resp_timer #(
        .RESP_W (RESP_W)
    ) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_end),
        .tick    (tick_en),
        .ticks   (resp_ticks)
    );

endmodule

// File: rtl/pptx_checker.sv
// Protocol checker for pulse_pause_tx, attached by bind.
module pptx_checker #(
    parameter int RESP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              tick_en,
    input logic              ks_adv,
    input logic              carrier,
    input logic              busy,
    input logic              done,
    input logic [RESP_W-1:0] resp_ticks
);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (carrier && !busy));

    // R6
    done_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!carrier));

    // R9
    resp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (resp_ticks == '0));

    // R11
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_en) |=> ($stable(carrier) && busy));

    // R5
    adv_then_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_adv |=> (busy && !carrier));

    // R7
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind pulse_pause_tx pptx_checker #(
    .RESP_W (RESP_W)
) u_pptx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tick_en    (tick_en),
    .ks_adv     (ks_adv),
    .carrier    (carrier),
    .busy       (busy),
    .done       (done),
    .resp_ticks (resp_ticks)
);

// File: tb/test_pulse_pause_tx.sv
`timescale 1ns/1ps
module test_pulse_pause_tx;

    localparam int DW    = 16;
    localparam int PT    = 3;
    localparam int OT    = 11;
    localparam int ZT    = 7;
    localparam int RW    = 5;
    localparam int CW    = $clog2(DW + 1);
    localparam int RMAX  = (1 << RW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [CW-1:0] nbits_in = '0;
    logic          ks_bit;
    logic          ks_adv;
    logic          carrier;
    logic          busy;
    logic          done;
    logic [RW-1:0] resp_ticks;

    int n_cmp = 0;
    int n_bad = 0;
    int div = 1;
    int dcnt = 0;
    bit hold = 1'b0;
    bit ks_on = 1'b0;
    bit cmp_on = 1'b0;
    logic [6:0] lfsr = 7'h5A;

    always #4 clk = ~clk;

    assign ks_bit = ks_on ? lfsr[0] : 1'b0;

    pulse_pause_tx #(
        .DATA_W (DW), .PAUSE_TICKS (PT), .ONE_TICKS (OT),
        .ZERO_TICKS (ZT), .RESP_W (RW)
    ) i_pulse_pause_tx (
        .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .start (start),
        .data_in (data_in), .nbits_in (nbits_in), .ks_bit (ks_bit),
        .ks_adv (ks_adv), .carrier (carrier), .busy (busy), .done (done),
        .resp_ticks (resp_ticks)
    );

    // External keystream generator, stepped by the advance strobe.
    always @(posedge clk) if (ks_adv) lfsr <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};

    // Tick generator: one tick every div cycles unless held.
    always @(negedge clk) begin
        if (hold) tick_en = 1'b0;
        else begin
            tick_en = (dcnt == 0);
            dcnt = (dcnt + 1 >= div) ? 0 : dcnt + 1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase, elapsed ticks, queue of pending bits.
    int ph = 0;
    int el = 0;
    int cur = 0;
    int q[$];
    int m_done = 0;
    int m_resp = 0;

    always @(posedge clk) begin
        int ne;
        int close_evt;
        if (!rst_n) begin
            ph = 0; el = 0; cur = 0; q.delete(); m_done = 0; m_resp = 0;
        end else begin
            close_evt = (ph == 3 && tick_en && el + 1 == PT) ? 1 : 0;
            m_done = close_evt;
            m_resp = close_evt ? 0 : ((tick_en && m_resp < RMAX) ? m_resp + 1 : m_resp);
            case (ph)
                0: if (start) begin
                    ne = (int'(nbits_in) > DW) ? DW : int'(nbits_in);
                    q.delete();
                    for (int i = 0; i < ne; i++) q.push_back(int'(data_in[i]));
                    el = 0;
                    if (ne == 0) ph = 3;
                    else begin cur = q.pop_front() ^ int'(ks_bit); ph = 1; end
                end
                1: if (tick_en) begin el++; if (el == PT) ph = 2; end
                2: if (tick_en) begin
                    el++;
                    if (el == (cur ? OT : ZT)) begin
                        el = 0;
                        if (q.size() == 0) ph = 3;
                        else begin cur = q.pop_front() ^ int'(ks_bit); ph = 1; end
                    end
                end
                default: if (tick_en) begin el++; if (el == PT) begin ph = 0; el = 0; end end
            endcase
        end
    end

    // Every-cycle comparison against the reference, away from the edge.
    always @(negedge clk) begin
        int e_adv;
        #2;
        if (cmp_on) begin
            e_adv = ((ph == 0 && start && nbits_in != 0) ||
                     (ph == 2 && tick_en && el + 1 == (cur ? OT : ZT) && q.size() > 0)) ? 1 : 0;
            check("R3", "carrier", int'(carrier), (ph == 1 || ph == 3) ? 0 : 1);
            check("R7", "busy", int'(busy), (ph != 0) ? 1 : 0);
            check("R8", "done", int'(done), m_done);
            check("R5", "ks_adv", int'(ks_adv), e_adv);
            check("R9", "resp_ticks", int'(resp_ticks), m_resp);
        end
    end

    // Send a frame and compare carrier run lengths (div must be 1).
    task automatic send(input logic [DW-1:0] d, input int n, input bit poke,
                        input string req);
        int runs[$];
        int exp[$];
        int ne;
        int run;
        int lvl;
        int cyc;
        logic [6:0] lc;
        ne = (n > DW) ? DW : n;
        lc = lfsr;
        for (int i = 0; i < ne; i++) begin
            int e;
            e = int'(d[i]) ^ (ks_on ? int'(lc[0]) : 0);
            lc = {lc[5:0], lc[6] ^ lc[5]};
            exp.push_back(PT);
            exp.push_back((e ? OT : ZT) - PT);
        end
        exp.push_back(PT);
        @(negedge clk);
        start = 1'b1; data_in = d; nbits_in = CW'(n);
        run = 0; lvl = 0; cyc = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (poke && cyc == 5) begin start = 1'b1; data_in = ~d; nbits_in = CW'(1); end
            #2;
            cyc++;
            if (done || cyc > 2000) break;
            if (int'(carrier) == lvl) run++;
            else begin runs.push_back(run); lvl = int'(carrier); run = 1; end
        end
        runs.push_back(run);
        check(req, "run count", runs.size(), exp.size());
        for (int i = 0; i < exp.size() && i < runs.size(); i++)
            check(req, (i % 2 == 0) ? "low run" : "high run", runs[i], exp[i]);
        // R9 restart at frame end
        check("R9", "resp at done", int'(resp_ticks), 0);
        @(negedge clk); #2;
        // R8 single-cycle pulse
        check("R8", "done width", int'(done), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        check("R1", "carrier", int'(carrier), 1);
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "ks_adv", int'(ks_adv), 0);
        check("R1", "resp", int'(resp_ticks), 0);
        cmp_on = 1'b1;

        // R2 R3 R4: plain frames, keystream tied low
        send(16'hA5C3, 16, 1'b0, "R4");
        send(16'h0001, 5, 1'b0, "R3");
        send(16'h00F0, 9, 1'b0, "R2");
        // R6: empty frame gives only the closing pause
        send(16'hFFFF, 0, 1'b0, "R6");
        // R5: whitened frames
        ks_on = 1'b1;
        send(16'h1234, 12, 1'b0, "R5");
        send(16'hFFFF, 16, 1'b0, "R5");
        // R7: start during a frame is ignored
        send(16'h3C5A, 10, 1'b1, "R7");
        // R10: count above the payload width
        send(16'h8E71, 20, 1'b0, "R10");

        // R11: stalled ticks freeze the frame
        @(negedge clk);
        start = 1'b1; data_in = 16'h0055; nbits_in = CW'(8);
        @(negedge clk); start = 1'b0;
        repeat (9) @(negedge clk);
        hold = 1'b1;
        @(negedge clk); #2;
        begin
            logic c0;
            logic b0;
            bit same;
            c0 = carrier; b0 = busy; same = 1'b1;
            repeat (20) begin @(negedge clk); #2; if (carrier !== c0 || busy !== b0) same = 1'b0; end
            check("R11", "stall stable", int'(same), 1);
        end
        hold = 1'b0;
        while (!done) begin @(negedge clk); #2; end

        // Slow ticks, reference model only
        div = 3;
        @(negedge clk);
        start = 1'b1; data_in = 16'h6B2D; nbits_in = CW'(14);
        @(negedge clk); start = 1'b0;
        repeat (600) @(negedge clk);
        div = 1;

        // R9 saturation of the response window counter
        repeat (RMAX + 10) @(negedge clk);
        #2;
        check("R9", "resp saturated", int'(resp_ticks), RMAX);

        @(negedge clk);
        cmp_on = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule